// File: doc/BRIEF.md
# Eight-Operation ALU with Flags Register

This block computes one of eight arithmetic, logic or single-bit shift operations on two operands, A and B, chosen by a 3-bit operation code. The result path is purely combinational, so the result follows the inputs in the same cycle. A 4-bit status register sits beside the datapath. It records zero, negative, carry and overflow conditions for the operation on the inputs at a rising clock edge.

The status register is written only when the write-enable input is high and the selected operation is one that produces flags. Shifts never touch it. A surrounding sequencer drives the operands and operation code, takes the result, and raises the write-enable in the step where the status should be kept. Operand registers, bus drivers and sequencing live outside this block. The operand width is a parameter (default 8). The status register has one state variable, its 4-bit value, and two transitions: a load when written and a hold otherwise. A synchronous reset clears it.

Top module: `alu_flags_top`

## Requirements
- R1: Operation code 3'b000 adds: `result` equals (A + B) modulo 2^WIDTH.
- R2: Operation code 3'b001 subtracts: `result` equals (A + ~B + 1) modulo 2^WIDTH, which is A − B.
- R3: Operation codes 3'b010, 3'b011, 3'b100 and 3'b101 give bitwise A AND B, A OR B, A XOR B, and NOT A, in that order.
- R4: Operation code 3'b110 shifts A left by one and 3'b111 shifts A right by one. Each fills the vacated bit with 0 and ignores B.
- R5: `flags_q` holds bit 3 = Z, bit 2 = N, bit 1 = C, bit 0 = V. When `flag_we` is high at a rising edge and the code is 3'b000 to 3'b101, Z becomes 1 exactly when the result is all zeros, and N becomes the result's top bit.
- R6: On a write for ADD or SUB, C becomes the carry out of the top adder bit. For SUB this carry comes from A + ~B + 1, so C = 1 when A ≥ B unsigned.
- R7: On a write for ADD or SUB, V becomes the XOR of the carry into the top bit and the carry out of it. That is the two's-complement overflow.
- R8: On a write for AND, OR, XOR or NOT, C and V both become 0.
- R9: For codes 3'b110 and 3'b111, `flags_q` keeps its value even when `flag_we` is high.
- R10: While `flag_we` is low, `flags_q` keeps its value for every code.
- R11: When `rst` is high at a rising edge, `flags_q` becomes 4'b0000, taking priority over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| op_sel | input | 3 | Operation code |
| flag_we | input | 1 | Status write enable |
| result | output | WIDTH | Combinational result |
| flags_q | output | 4 | Registered status {Z, N, C, V} |

## Verification
The bench builds the block with WIDTH set to 8, the default. At that width, uniformly drawn operands reach signed overflow in both directions, unsigned wrap of the adder and borrow on subtraction often. The directed cases pin the exact boundaries: 0x7F + 1, 0xFF + 1, 0x80 − 1, 0 − 1 and equal-operand subtraction. Random write-enable and operation choices also put every shift-with-enable and hold case next to a preceding write whose value must survive.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_BITS   = 3;
    localparam int FLAG_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_NOT = 3'b101,
        OP_SHL = 3'b110,
        OP_SHR = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_sets_flags(alu_op_e op);
        return (op != OP_SHL) && (op != OP_SHR);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             carry_msb
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign b_eff    = b ^ {WIDTH{sub}};
    assign chain[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic half;
        assign half       = a[i] ^ b_eff[i];
        assign sum[i]     = half ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & half);
    end

    assign carry_out = chain[WIDTH];
    assign carry_msb = chain[WIDTH-1];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] result
);
    always_comb begin
        result = '0;
        unique case (op)
            OP_ADD,
            OP_SUB: result = sum;
            OP_AND: result = a & b;
            OP_OR:  result = a | b;
            OP_XOR: result = a ^ b;
            OP_NOT: result = ~a;
            OP_SHL: result = {a[WIDTH-2:0], 1'b0};
            OP_SHR: result = {1'b0, a[WIDTH-1:1]};
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] result,
    input  logic             carry_out,
    input  logic             carry_msb,
    input  logic             flag_we,
    output logic             load,
    output alu_flags_t       next
);
    logic arith;

    assign arith = op_is_arith(op);
    assign load  = flag_we && op_sets_flags(op);

    always_comb begin
        next.z = ~|result;
        next.n = result[WIDTH-1];
        next.c = arith ? carry_out : 1'b0;
        next.v = arith ? (carry_msb ^ carry_out) : 1'b0;
    end
endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  alu_flags_t d,
    output alu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags_q
);
    alu_op_e          op;
    logic [WIDTH-1:0] sum;
    logic             carry_out;
    logic             carry_msb;
    logic             load;
    alu_flags_t       next_flags;
    alu_flags_t       cur_flags;

    assign op = alu_op_e'(op_sel);

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (op == OP_SUB),
        .sum       (sum),
        .carry_out (carry_out),
        .carry_msb (carry_msb)
    );

    alu_result_mux #(.WIDTH(WIDTH)) u_mux (
        .op     (op),
        .a      (opnd_a),
        .b      (opnd_b),
        .sum    (sum),
        .result (result)
    );

    alu_flag_gen #(.WIDTH(WIDTH)) u_fgen (
        .op        (op),
        .result    (result),
        .carry_out (carry_out),
        .carry_msb (carry_msb),
        .flag_we   (flag_we),
        .load      (load),
        .next      (next_flags)
    );

    alu_flags_reg u_freg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (next_flags),
        .q    (cur_flags)
    );

    assign flags_q = cur_flags;
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic             flag_we,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags_q
);
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> flags_q == 4'b0000);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> flags_q == $past(flags_q));

    p_shift_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel[2:1] == 2'b11) |=> flags_q == $past(flags_q));

    p_zero_neg_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel <= 3'd5) |=>
            (flags_q[3] == ($past(result) == '0)) &&
            (flags_q[2] == $past(result[WIDTH-1])));

    p_logic_cv_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel >= 3'd2 && op_sel <= 3'd5) |=> flags_q[1:0] == 2'b00);

    p_shl_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b110) |-> result[0] == 1'b0);

    p_shr_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b111) |-> result[WIDTH-1] == 1'b0);
endmodule

bind alu_flags_top alu_flags_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .flag_we (flag_we),
    .result  (result),
    .flags_q (flags_q)
);

// File: tb/alu_flags_top_tb.sv
module alu_flags_top_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [2:0]   op_sel = '0;
    logic         flag_we = 1'b0;
    logic [W-1:0] result;
    logic [3:0]   flags_q;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic [3:0] model = 4'b0000;

    always #2 clk = ~clk;

    alu_flags_top #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .flag_we(flag_we), .result(result), .flags_q(flags_q)
    );

    function automatic logic [W-1:0] exp_result(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op);
        case (op)
            3'd0: return W'(a + b);
            3'd1: return W'(a - b);
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return ~a;
            3'd6: return W'(a * 2);
            default: return a / 2;
        endcase
    endfunction

    function automatic logic [3:0] exp_flags(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic c, v;
        r = exp_result(a, b, op);
        c = 1'b0;
        v = 1'b0;
        if (op == 3'd0) begin
            s = {1'b0, a} + {1'b0, b};
            c = s[W];
            v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
        end else if (op == 3'd1) begin
            c = (a >= b);
            v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        end
        return {(r == '0), r[W-1], c, v};
    endfunction

    function automatic string res_tag(logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd6, 3'd7: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, logic we);
        string ftag;
        @(negedge clk);
        opnd_a  = a;
        opnd_b  = b;
        op_sel  = op;
        flag_we = we;
        #1;
        check(res_tag(op), 32'(result), 32'(exp_result(a, b, op)));
        if (!we)                 ftag = "R10 hold";
        else if (op >= 3'd6)     ftag = "R9 shift keeps flags";
        else if (op >= 3'd2)     ftag = "R5 R8 logic flags";
        else                     ftag = "R5 R6 R7 arith flags";
        if (we && op <= 3'd5) model = exp_flags(a, b, op);
        @(posedge clk);
        #1;
        check(ftag, 32'(flags_q), 32'(model));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", 32'(flags_q), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        apply(8'h7F, 8'h01, 3'd0, 1'b1);   // R7 overflow, N set
        apply(8'hFF, 8'h01, 3'd0, 1'b1);   // R6 carry, Z set
        apply(8'h05, 8'h05, 3'd1, 1'b1);   // R2 equal: Z and C
        apply(8'h80, 8'h01, 3'd1, 1'b1);   // R7 SUB overflow
        apply(8'h00, 8'h01, 3'd1, 1'b1);   // R6 borrow: C clear
        apply(8'h81, 8'h00, 3'd6, 1'b1);   // R9 SHL keeps
        apply(8'h81, 8'hFF, 3'd7, 1'b1);   // R9 SHR keeps
        apply(8'h0F, 8'h00, 3'd5, 1'b1);   // R8 NOT clears C V
        apply(8'h00, 8'h00, 3'd0, 1'b0);   // R10 hold
        apply(8'hFF, 8'h7F, 3'd0, 1'b1);
        apply(8'hF0, 8'h0F, 3'd2, 1'b1);   // R3 AND zero
        apply(8'hF0, 8'h0F, 3'd3, 1'b1);
        apply(8'hAA, 8'h55, 3'd4, 1'b1);

        for (int i = 0; i < 600; i++) begin
            apply(W'($urandom), W'($urandom), 3'($urandom), 1'($urandom));
        end

        // R11: reset beats a simultaneous write
        apply(8'h80, 8'h80, 3'd0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        opnd_a = 8'h80; opnd_b = 8'h80; op_sel = 3'd0; flag_we = 1'b1;
        @(posedge clk);
        #1;
        check("R11 reset over write", 32'(flags_q), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule